// File: doc/BRIEF.md
# Alternating-Reload PWM Timer with External Trigger

The block is a down-counting timer that produces a pulse-width-modulated waveform with no processor help once it is set up. Two reload registers hold the high and low durations. Each time the counter underflows, it takes its new value from one of the two registers, switching between them on each underflow. An optional toggle makes the output pin change level on every underflow. Software can ask for an interrupt on reloads from either register. This gives one interrupt per period on a chosen edge, or one interrupt on every edge.

A halted mode stops the counter. In this mode the output pin follows a general-purpose data bit in the control word. If the arm bit is set, a rising edge on the trigger input moves the block from halted into PWM operation. Counting then continues from the counter's current value. This produces a delayed pulse triggered by an external event. The register bus is reduced to plain write strobes with a shared data word.

Top module: `pwm_alt_timer`

## Requirements
- R1: After reset the counter, the output, both pending flags and the interrupt line are 0, and the block is halted with every control field at 0.
- R2: The control word bits are: bit 0 run (1 = PWM mode, 0 = halted), bits 2:1 rate, bit 3 toggle enable, bit 4 A-reload interrupt enable, bit 5 B-reload interrupt enable, bit 6 general-purpose output data, bit 7 trigger arm. In PWM mode with rate r, the counter advances once every 2^r clocks. The prescaler restarts whenever the block is halted, so the first advance lands 2^r clocks after the clock edge that enters PWM mode.
- R3: When an advance finds the counter at 0, the counter is reloaded on that same advance instead of decrementing. The first reload after each entry into PWM mode comes from register A. Later reloads alternate B, A, B, and so on.
- R4: When toggle enable is 1, the output pin inverts on every reload. When toggle enable is 0, the output pin keeps its level.
- R5: A reload from A sets pending bit 0 if the A interrupt enable is 1. A reload from B sets pending bit 1 if the B interrupt enable is 1. The interrupt line is the OR of the two pending bits.
- R6: Pending bits stay set until software writes a 1 to the matching bit of the clear strobe. A set arriving in the same cycle as a clear wins.
- R7: While halted, the counter holds its value unless it is written, and the output pin equals the general-purpose data bit. On entering PWM mode the output starts from that same level.
- R8: The trigger input passes through a two-flop synchronizer. A rising edge after the synchronizer, seen while the block is halted with arm set, enters PWM mode and clears arm. Without arm, the edge has no effect.
- R9: Registers A and B are read only at the moment of a reload. A write takes effect at the next reload from that register and does not change the count in progress.
- R10: A counter write loads the data word into the counter on the next edge. It takes priority over any advance in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word (fields listed in R2) |
| rega_we | input | 1 | Write strobe for reload register A |
| regb_we | input | 1 | Write strobe for reload register B |
| cnt_we | input | 1 | Write strobe for the counter |
| wdata | input | CNT_W (16) | Data word for register A, register B and the counter |
| clr_we | input | 1 | Pending-flag clear strobe |
| clr_wdata | input | 2 | Write-one-to-clear mask; bit 0 = A flag, bit 1 = B flag |
| trig_in | input | 1 | Asynchronous external trigger |
| pwm_out | output | 1 | Output pin |
| count | output | CNT_W (16) | Current counter value |
| irq_pend | output | 2 | Pending flags; bit 0 = A reload, bit 1 = B reload |
| irq | output | 1 | Interrupt request, the OR of the pending flags |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a two-flop synchronizer. Reload values are kept small, so that many full A/B periods fit in the run. A reference model, advanced on every clock, covers all four rates, including a rate change while counting. It also covers a register-A update in the middle of a period, a clear that collides with a set, halted output driving, a trigger that arrives without arm, and an armed triggered start from a preloaded count.

// File: rtl/pwm_alt_pkg.sv
package pwm_alt_pkg;

    localparam int RATE_W = 2;
    localparam int PRE_W  = (1 << RATE_W) - 1;
    localparam int IRQ_N  = 2;
    localparam int IRQ_A  = 0;
    localparam int IRQ_B  = 1;

    typedef struct packed {
        logic              arm;
        logic              gpo;
        logic              irqb_en;
        logic              irqa_en;
        logic              tog_en;
        logic [RATE_W-1:0] rate;
        logic              run;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic {
        SEL_A = 1'b0,
        SEL_B = 1'b1
    } sel_e;

    function automatic logic [PRE_W-1:0] rate_mask(input logic [RATE_W-1:0] r);
        logic [PRE_W-1:0] m;
        for (int i = 0; i < PRE_W; i++) begin
            m[i] = (i < int'(r));
        end
        return m;
    endfunction

    function automatic sel_e sel_flip(input sel_e s);
        return (s == SEL_A) ? SEL_B : SEL_A;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_alt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    assign mask = rate_mask(rate);
    assign tick = run && ((pre & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre <= '0;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && rate != '0) |=> (!tick || !$stable(rate))) else $error("tick spacing"); // R2

endmodule

// File: rtl/pwm_trig_sync.sv
module pwm_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);

    logic [STAGES:0] sh;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[g] <= 1'b0;
                else     sh[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[g] <= 1'b0;
                else     sh[g] <= sh[g-1];
            end
        end
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise) else $error("trigger edge longer than one cycle"); // R8

endmodule

// File: rtl/pwm_reload_core.sv
module pwm_reload_core
    import pwm_alt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             enter,
    input  logic             tick,
    input  logic             tog_en,
    input  logic             gpo,
    input  logic             rega_we,
    input  logic             regb_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             pq,
    output logic             evt_a,
    output logic             evt_b
);

    logic [CNT_W-1:0] rega;
    logic [CNT_W-1:0] regb;
    sel_e             sel;
    logic             uf;

    assign uf    = tick && (count == '0) && !cnt_we;
    assign evt_a = uf && (sel == SEL_A);
    assign evt_b = uf && (sel == SEL_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            rega <= '0;
            regb <= '0;
        end else begin
            if (rega_we) rega <= wdata;
            if (regb_we) regb <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cnt_we) begin
            count <= wdata;
        end else if (uf) begin
            count <= (sel == SEL_A) ? rega : regb;
        end else if (tick) begin
            count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SEL_A;
        end else if (enter) begin
            sel <= SEL_A;
        end else if (uf) begin
            sel <= sel_flip(sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pq <= 1'b0;
        end else if (!run) begin
            pq <= gpo;
        end else if (uf && tog_en) begin
            pq <= ~pq;
        end
    end

    AST_RELOAD_A: assert property (@(posedge clk) disable iff (rst)
        evt_a |=> count == $past(rega)) else $error("A reload value"); // R3
    AST_RELOAD_B: assert property (@(posedge clk) disable iff (rst)
        evt_b |=> count == $past(regb)) else $error("B reload value"); // R3
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (tick && !uf && !cnt_we) |=> count == $past(count) - 1'b1) else $error("decrement"); // R2
    AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (uf && tog_en) |=> pq != $past(pq)) else $error("toggle"); // R4
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_we) |=> $stable(count)) else $error("halted count moved"); // R7
    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> count == $past(wdata)) else $error("counter write"); // R10

endmodule

// File: rtl/pwm_irq_flags.sv
module pwm_irq_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[i] <= 1'b0;
            end else if (set[i]) begin
                pend[i] <= 1'b1;
            end else if (clr_we && clr[i]) begin
                pend[i] <= 1'b0;
            end
        end

        AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> pend[i]) else $error("flag not set"); // R5
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
            (pend[i] && !(clr_we && clr[i])) |=> pend[i]) else $error("flag dropped"); // R6
    end

endmodule

// File: rtl/pwm_alt_timer.sv
module pwm_alt_timer
    import pwm_alt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             rega_we,
    input  logic             regb_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             clr_we,
    input  logic [IRQ_N-1:0] clr_wdata,
    input  logic             trig_in,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count,
    output logic [IRQ_N-1:0] irq_pend,
    output logic             irq
);

    ctl_t             ctl;
    ctl_t             wctl;
    logic             rise;
    logic             trig_go;
    logic             enter;
    logic             tick;
    logic             pq;
    logic             evt_a;
    logic             evt_b;
    logic [IRQ_N-1:0] irq_set;

    assign wctl    = ctl_t'(ctl_wdata);
    assign trig_go = !ctl.run && ctl.arm && rise && !ctl_we;
    assign enter   = !ctl.run && (ctl_we ? wctl.run : trig_go);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (ctl_we) begin
            ctl <= wctl;
        end else if (trig_go) begin
            ctl.run <= 1'b1;
            ctl.arm <= 1'b0;
        end
    end

    pwm_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (trig_in),
        .rise (rise)
    );

    pwm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctl.run),
        .rate (ctl.rate),
        .tick (tick)
    );

    pwm_reload_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl.run),
        .enter   (enter),
        .tick    (tick),
        .tog_en  (ctl.tog_en),
        .gpo     (ctl.gpo),
        .rega_we (rega_we),
        .regb_we (regb_we),
        .cnt_we  (cnt_we),
        .wdata   (wdata),
        .count   (count),
        .pq      (pq),
        .evt_a   (evt_a),
        .evt_b   (evt_b)
    );

    assign irq_set[IRQ_A] = evt_a && ctl.irqa_en;
    assign irq_set[IRQ_B] = evt_b && ctl.irqb_en;

    pwm_irq_flags #(.N(IRQ_N)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .set    (irq_set),
        .clr_we (clr_we),
        .clr    (clr_wdata),
        .pend   (irq_pend)
    );

    assign pwm_out = ctl.run ? pq : ctl.gpo;
    assign irq     = |irq_pend;

    AST_NO_ARM_NO_START: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && !ctl.arm && !ctl_we) |=> !ctl.run) else $error("start without arm"); // R8
    AST_ARMED_START: assert property (@(posedge clk) disable iff (rst)
        (!ctl.run && ctl.arm && rise && !ctl_we) |=> (ctl.run && !ctl.arm)) else $error("armed start"); // R8
    AST_EVT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (evt_a || evt_b) |-> $past(ctl.run) || ctl.run) else $error("reload while halted"); // R3

endmodule

// File: tb/pwm_alt_timer_test.sv
module pwm_alt_timer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_we;
    logic [7:0]  ctl_wdata;
    logic        rega_we;
    logic        regb_we;
    logic        cnt_we;
    logic [15:0] wdata;
    logic        clr_we;
    logic [1:0]  clr_wdata;
    logic        trig_in;
    logic        pwm_out;
    logic [15:0] count;
    logic [1:0]  irq_pend;
    logic        irq;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    pwm_alt_timer uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rega_we(rega_we), .regb_we(regb_we), .cnt_we(cnt_we), .wdata(wdata),
        .clr_we(clr_we), .clr_wdata(clr_wdata), .trig_in(trig_in),
        .pwm_out(pwm_out), .count(count), .irq_pend(irq_pend), .irq(irq)
    );

    // behavioural reference model state
    int m_run, m_rate, m_tog, m_iea, m_ieb, m_gpo, m_arm;
    int m_a, m_b, m_cnt, m_next_b, m_pin, m_pa, m_pb, m_pre;
    int hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_rate = 0; m_tog = 0; m_iea = 0; m_ieb = 0; m_gpo = 0; m_arm = 0;
            m_a = 0; m_b = 0; m_cnt = 0; m_next_b = 0; m_pin = 0; m_pa = 0; m_pb = 0; m_pre = 0;
            hist = '{0, 0, 0};
        end else begin
            automatic int edge_seen = (hist[1] == 1 && hist[2] == 0);
            automatic int period = 1 << m_rate;
            automatic int adv = m_run && ((m_pre % period) == period - 1);
            automatic int under = adv && (m_cnt == 0) && !cnt_we;
            automatic int go = !m_run && m_arm && edge_seen && !ctl_we;
            automatic int was_run = m_run;
            automatic int new_run;
            hist.push_front(int'(trig_in));
            void'(hist.pop_back());
            // output level
            if (!was_run) m_pin = m_gpo;
            else if (under && m_tog) m_pin = 1 - m_pin;
            // flags
            if (under && !m_next_b && m_iea) m_pa = 1;
            else if (clr_we && clr_wdata[0]) m_pa = 0;
            if (under && m_next_b && m_ieb) m_pb = 1;
            else if (clr_we && clr_wdata[1]) m_pb = 0;
            // counter
            if (cnt_we) m_cnt = int'(wdata);
            else if (under) m_cnt = m_next_b ? m_b : m_a;
            else if (adv) m_cnt = (m_cnt + 65535) % 65536;
            if (under) m_next_b = 1 - m_next_b;
            if (rega_we) m_a = int'(wdata);
            if (regb_we) m_b = int'(wdata);
            m_pre = was_run ? (m_pre + 1) % 8 : 0;
            // control
            if (ctl_we) begin
                new_run = ctl_wdata[0];
                m_rate = ctl_wdata[2:1]; m_tog = ctl_wdata[3]; m_iea = ctl_wdata[4];
                m_ieb = ctl_wdata[5]; m_gpo = ctl_wdata[6]; m_arm = ctl_wdata[7];
            end else if (go) begin
                new_run = 1; m_arm = 0;
            end else begin
                new_run = m_run;
            end
            if (new_run && !was_run) m_next_b = 0;
            m_run = new_run;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            automatic int exp_out = m_run ? m_pin : m_gpo;
            check(int'(count) == m_cnt, phase, "count", int'(count), m_cnt);
            check(int'(pwm_out) == exp_out, phase, "pwm_out", int'(pwm_out), exp_out);
            check(int'(irq_pend) == m_pb * 2 + m_pa, phase, "irq_pend", int'(irq_pend), m_pb * 2 + m_pa);
            check(int'(irq) == (m_pa | m_pb), phase, "irq", int'(irq), m_pa | m_pb);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic logic [7:0] cw(int run, int rate, int tog, int iea, int ieb, int gpo, int arm);
        return {arm[0], gpo[0], ieb[0], iea[0], tog[0], rate[1:0], run[0]};
    endfunction

    task automatic wait_n(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(logic [7:0] v);
        ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
    endtask

    task automatic wr_a(int v);
        rega_we = 1; wdata = v[15:0]; @(negedge clk); rega_we = 0;
    endtask

    task automatic wr_b(int v);
        regb_we = 1; wdata = v[15:0]; @(negedge clk); regb_we = 0;
    endtask

    task automatic wr_cnt(int v);
        cnt_we = 1; wdata = v[15:0]; @(negedge clk); cnt_we = 0;
    endtask

    task automatic pulse_trig(int len);
        trig_in = 1; wait_n(len); trig_in = 0;
    endtask

    initial begin
        automatic int held;
        rst = 1; ctl_we = 0; ctl_wdata = 0; rega_we = 0; regb_we = 0; cnt_we = 0;
        wdata = 0; clr_we = 0; clr_wdata = 0; trig_in = 0;
        wait_n(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(count == 16'd0 && pwm_out == 1'b0, "R1", "count/out after reset", int'(count), 0);
        check(irq_pend == 2'b00 && irq == 1'b0, "R1", "flags after reset", int'(irq_pend), 0);

        phase = "R10";
        wr_a(5); wr_b(3); wr_cnt(2);
        check(count == 16'd2, "R10", "counter write", int'(count), 2);
        wr_cnt(0);

        phase = "R3";
        wr_ctl(cw(1, 0, 1, 1, 0, 0, 0));
        @(negedge clk);
        check(count == 16'd5, "R3", "first reload from A", int'(count), 5);
        check(pwm_out == 1'b1, "R4", "toggle on A reload", int'(pwm_out), 1);
        check(irq_pend == 2'b01, "R5", "A flag set", int'(irq_pend), 1);
        wait_n(6);
        check(count == 16'd3, "R3", "second reload from B", int'(count), 3);
        wait_n(30);

        phase = "R6";
        clr_we = 1; clr_wdata = 2'b11; @(negedge clk); clr_we = 0;
        wait_n(20);
        clr_we = 1; clr_wdata = 2'b01; wait_n(15); clr_we = 0;

        phase = "R2";
        wr_ctl(cw(1, 2, 1, 0, 1, 0, 0));
        wait_n(60);
        phase = "R9";
        wr_a(9);
        wait_n(80);
        phase = "R2";
        wr_ctl(cw(1, 3, 0, 1, 1, 0, 0));
        wait_n(100);
        wr_ctl(cw(1, 1, 1, 1, 1, 0, 0));
        wait_n(50);

        phase = "R7";
        wr_ctl(cw(0, 1, 1, 1, 1, 1, 0));
        held = int'(count);
        wait_n(10);
        check(int'(count) == held, "R7", "halted count hold", int'(count), held);
        check(pwm_out == 1'b1, "R7", "halted output follows data bit", int'(pwm_out), 1);
        wr_ctl(cw(0, 0, 1, 1, 1, 0, 0));
        @(negedge clk);
        check(pwm_out == 1'b0, "R7", "halted output low", int'(pwm_out), 0);

        phase = "R8";
        wr_cnt(4);
        pulse_trig(3);
        wait_n(8);
        check(count == 16'd4, "R8", "trigger ignored without arm", int'(count), 4);
        wr_ctl(cw(0, 0, 1, 1, 1, 0, 1));
        pulse_trig(4);
        wait_n(60);
        wr_ctl(cw(0, 0, 1, 0, 0, 1, 1));
        wr_cnt(2);
        pulse_trig(2);
        wait_n(40);
        finish_run();
    end

endmodule